// File: doc/BRIEF.md
# Prioritized Exception Entry Controller

This block decides which processor exception is entered when one or more exception requests are raised in a clock cycle, and produces everything the core needs to perform that entry in one step. Seven request lines are presented each cycle together with the current program counter and the current program status word. The interrupt request and fast interrupt request lines are masked by the disable bits held in that status word. The highest-priority surviving request wins.

One clock edge after the request cycle, the block pulses an entry strobe. With it come the privileged mode to enter, the vector address to branch to, and the return link value, which is the program counter sampled in the request cycle. It also provides the saved status, which is the status word sampled in that cycle, and the new status word to install. The register file writes the link and the saved status into the banked registers of the new mode on that strobe. Between entries the outputs keep their last values.

Request line order (bit index, highest priority first): 0 reset, 1 data abort, 2 fast interrupt, 3 interrupt, 4 prefetch abort, 5 undefined instruction, 6 software interrupt. Bits 5 and 6 share the lowest level.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `entry_o` is 0 and `mode_o`, `vector_o`, `link_o`, `spsr_o` and `new_psr_o` are all zero.
- R2: Of the unmasked requests in a cycle, the one taken is the lowest bit index in the order reset(0), data abort(1), fast interrupt(2), interrupt(3), prefetch abort(4), undefined(5), software interrupt(6).
- R3: `mode_o` and `new_psr_o[4:0]` equal the target mode: 5'b10011 for reset and software interrupt, 5'b10111 for both aborts, 5'b10001 for fast interrupt, 5'b10010 for interrupt, 5'b11011 for undefined.
- R4: `vector_o` is 0x00 reset, 0x04 undefined, 0x08 software interrupt, 0x0C prefetch abort, 0x10 data abort, 0x18 interrupt, 0x1C fast interrupt.
- R5: On an entry, `link_o` equals `pc_i` from the request cycle.
- R6: On an entry, `spsr_o` equals `psr_i` from the request cycle.
- R7: On an entry, `new_psr_o` equals the request-cycle `psr_i` with bit 7 (interrupt disable) set, bit 5 (state bit) cleared, bit 6 (fast disable) set for reset and fast interrupt entries and otherwise unchanged, and bits above 7 unchanged.
- R8: Request bit 3 is ignored while `psr_i[7]` is 1 and request bit 2 is ignored while `psr_i[6]` is 1; a masked request alone yields no entry and lets a lower-priority request win.
- R9: `entry_o` is high for exactly the cycle after each cycle with at least one unmasked request, and low otherwise; while it is low all other outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 7 | Exception request lines, bit order as above |
| pc_i | input | ADDR_W | Program counter of the interrupted flow |
| psr_i | input | PSR_W | Current status word (mode [4:0], state bit 5, fast disable 6, interrupt disable 7) |
| entry_o | output | 1 | One-cycle entry strobe |
| mode_o | output | 5 | Mode being entered |
| vector_o | output | ADDR_W | Vector address for the new program counter |
| link_o | output | ADDR_W | Value for the banked link register |
| spsr_o | output | PSR_W | Value for the banked saved status register |
| new_psr_o | output | PSR_W | Status word to install on entry |

## Verification
The assertions assume that the undefined-instruction and software-interrupt lines are never high in the same cycle. The stimulus honours this by skipping every request pattern with both bits 5 and 6 set. The sweep covers all remaining 96 request patterns against all four combinations of the two disable bits. The assertions also assume inputs are driven clear of the clock edge, so the bench changes them only on the falling edge.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int EXC_COUNT = 7;
  localparam int EXC_IDX_W = $clog2(EXC_COUNT);

  // Priority index of each source: lower index wins.
  localparam int SRC_RESET = 0;
  localparam int SRC_DABT  = 1;
  localparam int SRC_FIQ   = 2;
  localparam int SRC_IRQ   = 3;
  localparam int SRC_PABT  = 4;
  localparam int SRC_UND   = 5;
  localparam int SRC_SWI   = 6;

  // Status word field positions.
  localparam int PSR_I_BIT = 7;
  localparam int PSR_F_BIT = 6;
  localparam int PSR_T_BIT = 5;
  localparam int MODE_W    = 5;

  typedef enum logic [MODE_W-1:0] {
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011
  } exc_mode_e;

  function automatic exc_mode_e mode_of(input logic [EXC_IDX_W-1:0] idx);
    case (int'(idx))
      SRC_RESET: mode_of = MODE_SVC;
      SRC_DABT:  mode_of = MODE_ABT;
      SRC_FIQ:   mode_of = MODE_FIQ;
      SRC_IRQ:   mode_of = MODE_IRQ;
      SRC_PABT:  mode_of = MODE_ABT;
      SRC_UND:   mode_of = MODE_UND;
      default:   mode_of = MODE_SVC;
    endcase
  endfunction

  function automatic logic [7:0] vec_offset_of(input logic [EXC_IDX_W-1:0] idx);
    case (int'(idx))
      SRC_RESET: vec_offset_of = 8'h00;
      SRC_DABT:  vec_offset_of = 8'h10;
      SRC_FIQ:   vec_offset_of = 8'h1C;
      SRC_IRQ:   vec_offset_of = 8'h18;
      SRC_PABT:  vec_offset_of = 8'h0C;
      SRC_UND:   vec_offset_of = 8'h04;
      default:   vec_offset_of = 8'h08;
    endcase
  endfunction

  function automatic logic sets_fast_disable(input logic [EXC_IDX_W-1:0] idx);
    sets_fast_disable = (int'(idx) == SRC_RESET) || (int'(idx) == SRC_FIQ);
  endfunction

endpackage

// File: rtl/exc_req_mask.sv
module exc_req_mask
  import exc_pkg::*;
(
  input  logic [EXC_COUNT-1:0] req_i,
  input  logic                 irq_dis_i,
  input  logic                 fiq_dis_i,
  output logic [EXC_COUNT-1:0] req_o
);

  logic [EXC_COUNT-1:0] keep;

  always_comb begin
    keep           = '1;
    keep[SRC_IRQ]  = ~irq_dis_i;
    keep[SRC_FIQ]  = ~fiq_dis_i;
    req_o          = req_i & keep;
  end

endmodule

// File: rtl/exc_prio_arb.sv
module exc_prio_arb #(
  parameter int N     = 7,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     grant_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);

  logic [N:0] seen;

  assign seen[0] = 1'b0;

  for (genvar k = 0; k < N; k++) begin : g_chain
    assign seen[k+1]  = seen[k] | req_i[k];
    assign grant_o[k] = req_i[k] & ~seen[k];
  end

  assign any_o = seen[N];

  always_comb begin
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (grant_o[k]) idx_o = IDX_W'(k);
    end
  end

endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
  import exc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PSR_W  = 32
) (
  input  logic [EXC_IDX_W-1:0] idx_i,
  input  logic [PSR_W-1:0]     psr_i,
  output logic [MODE_W-1:0]    mode_o,
  output logic [ADDR_W-1:0]    vector_o,
  output logic [PSR_W-1:0]     new_psr_o
);

  exc_mode_e mode;

  always_comb begin
    mode      = mode_of(idx_i);
    mode_o    = mode;
    vector_o  = ADDR_W'(vec_offset_of(idx_i));
    new_psr_o = psr_i;
    new_psr_o[MODE_W-1:0] = mode;
    new_psr_o[PSR_I_BIT]  = 1'b1;
    new_psr_o[PSR_T_BIT]  = 1'b0;
    if (sets_fast_disable(idx_i)) new_psr_o[PSR_F_BIT] = 1'b1;
  end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PSR_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [EXC_COUNT-1:0] req_i,
  input  logic [ADDR_W-1:0]    pc_i,
  input  logic [PSR_W-1:0]     psr_i,
  output logic                 entry_o,
  output logic [MODE_W-1:0]    mode_o,
  output logic [ADDR_W-1:0]    vector_o,
  output logic [ADDR_W-1:0]    link_o,
  output logic [PSR_W-1:0]     spsr_o,
  output logic [PSR_W-1:0]     new_psr_o
);

  logic [EXC_COUNT-1:0] req_live;
  logic [EXC_COUNT-1:0] grant;
  logic [EXC_IDX_W-1:0] win_idx;
  logic                 win_any;
  logic [MODE_W-1:0]    nxt_mode;
  logic [ADDR_W-1:0]    nxt_vector;
  logic [PSR_W-1:0]     nxt_psr;

  exc_req_mask u_mask (
    .req_i     (req_i),
    .irq_dis_i (psr_i[PSR_I_BIT]),
    .fiq_dis_i (psr_i[PSR_F_BIT]),
    .req_o     (req_live)
  );

  exc_prio_arb #(.N(EXC_COUNT), .IDX_W(EXC_IDX_W)) u_arb (
    .req_i   (req_live),
    .grant_o (grant),
    .idx_o   (win_idx),
    .any_o   (win_any)
  );

  exc_entry_calc #(.ADDR_W(ADDR_W), .PSR_W(PSR_W)) u_calc (
    .idx_i     (win_idx),
    .psr_i     (psr_i),
    .mode_o    (nxt_mode),
    .vector_o  (nxt_vector),
    .new_psr_o (nxt_psr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry_o   <= 1'b0;
      mode_o    <= '0;
      vector_o  <= '0;
      link_o    <= '0;
      spsr_o    <= '0;
      new_psr_o <= '0;
    end else begin
      entry_o <= win_any;
      if (win_any) begin
        mode_o    <= nxt_mode;
        vector_o  <= nxt_vector;
        link_o    <= pc_i;
        spsr_o    <= psr_i;
        new_psr_o <= nxt_psr;
      end
    end
  end

endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk
  import exc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PSR_W  = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [EXC_COUNT-1:0] req_i,
  input logic [ADDR_W-1:0]    pc_i,
  input logic [PSR_W-1:0]     psr_i,
  input logic                 entry_o,
  input logic [MODE_W-1:0]    mode_o,
  input logic [ADDR_W-1:0]    vector_o,
  input logic [ADDR_W-1:0]    link_o,
  input logic [PSR_W-1:0]     spsr_o,
  input logic [PSR_W-1:0]     new_psr_o
);

  // R2
  reset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_i[SRC_RESET] |=> (entry_o && mode_o == MODE_SVC && vector_o == '0));

  // R3
  mode_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_o |-> (new_psr_o[MODE_W-1:0] == mode_o));

  // R5
  link_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_o |-> (link_o == $past(pc_i)));

  // R6
  spsr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_o |-> (spsr_o == $past(psr_i)));

  // R7
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_o |-> (new_psr_o[PSR_I_BIT] && !new_psr_o[PSR_T_BIT]));

  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == (EXC_COUNT'(1) << SRC_IRQ) && psr_i[PSR_I_BIT]) |=> !entry_o);

  // R9
  idle_no_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0) |=> !entry_o);

  // R9
  hold_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !entry_o |-> ($stable(link_o) && $stable(vector_o) && $stable(spsr_o)));

endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.ADDR_W(ADDR_W), .PSR_W(PSR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_i     (req_i),
  .pc_i      (pc_i),
  .psr_i     (psr_i),
  .entry_o   (entry_o),
  .mode_o    (mode_o),
  .vector_o  (vector_o),
  .link_o    (link_o),
  .spsr_o    (spsr_o),
  .new_psr_o (new_psr_o)
);

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  req_i = '0;
  logic [31:0] pc_i = '0;
  logic [31:0] psr_i = '0;
  logic        entry_o;
  logic [4:0]  mode_o;
  logic [31:0] vector_o, link_o, spsr_o, new_psr_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  exc_entry_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .pc_i(pc_i), .psr_i(psr_i),
    .entry_o(entry_o), .mode_o(mode_o), .vector_o(vector_o),
    .link_o(link_o), .spsr_o(spsr_o), .new_psr_o(new_psr_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_mode(input int s);
    case (s)
      0: return 5'b10011; 1: return 5'b10111; 2: return 5'b10001;
      3: return 5'b10010; 4: return 5'b10111; 5: return 5'b11011;
      default: return 5'b10011;
    endcase
  endfunction

  function automatic logic [31:0] exp_vec(input int s);
    case (s)
      0: return 32'h00; 1: return 32'h10; 2: return 32'h1C;
      3: return 32'h18; 4: return 32'h0C; 5: return 32'h04;
      default: return 32'h08;
    endcase
  endfunction

  initial begin
    logic [31:0] last_link, last_vec, last_spsr;
    @(negedge clk);
    @(negedge clk);
    // R1: state during reset
    chk("R1 entry", {31'b0, entry_o}, 32'h0);
    chk("R1 link", link_o, 32'h0);
    chk("R1 vector", vector_o, 32'h0);
    req_i = 7'h7F & ~7'h60;
    rst_n = 1'b1;
    req_i = '0;
    @(negedge clk);
    // R1: first cycle after reset
    chk("R1 entry after release", {31'b0, entry_o}, 32'h0);
    chk("R1 new_psr", new_psr_o, 32'h0);
    chk("R1 spsr", spsr_o, 32'h0);
    chk("R1 mode", {27'b0, mode_o}, 32'h0);

    for (int mf = 0; mf < 4; mf++) begin
      for (int r = 0; r < 128; r++) begin
        logic [6:0]  rq;
        logic [6:0]  live;
        logic [31:0] pc, psr, npsr;
        int          win;
        rq = 7'(r);
        if (rq[5] && rq[6]) continue;
        pc  = 32'h1000_0000 + 32'(r * 4) + 32'(mf << 12);
        psr = {24'hA50F3C ^ 24'(r * 3), mf[1], mf[0], 1'b1, 5'b10000};
        live = rq;
        if (psr[7]) live[3] = 1'b0;
        if (psr[6]) live[2] = 1'b0;
        win = -1;
        for (int k = 6; k >= 0; k--) if (live[k]) win = k;
        req_i = rq; pc_i = pc; psr_i = psr;
        last_link = link_o; last_vec = vector_o; last_spsr = spsr_o;
        @(negedge clk);
        if (win < 0) begin
          // R8 / R9: masked-only or empty request gives no entry, outputs hold
          chk("R9 no entry", {31'b0, entry_o}, 32'h0);
          chk("R8 link held", link_o, last_link);
          chk("R9 vector held", vector_o, last_vec);
          chk("R9 spsr held", spsr_o, last_spsr);
        end else begin
          npsr = psr;
          npsr[4:0] = exp_mode(win);
          npsr[7] = 1'b1;
          npsr[5] = 1'b0;
          if (win == 0 || win == 2) npsr[6] = 1'b1;
          chk("R9 entry", {31'b0, entry_o}, 32'h1);
          chk("R2/R4 vector", vector_o, exp_vec(win));
          chk("R3 mode", {27'b0, mode_o}, {27'b0, exp_mode(win)});
          chk("R5 link", link_o, pc);
          chk("R6 spsr", spsr_o, psr);
          chk("R7 new_psr", new_psr_o, npsr);
        end
        // R9: idle cycle after, strobe drops and values hold
        last_link = link_o; last_vec = vector_o;
        req_i = '0; pc_i = 32'hDEAD_0000; psr_i = 32'h0000_00D3;
        @(negedge clk);
        chk("R9 strobe single", {31'b0, entry_o}, 32'h0);
        chk("R9 link hold", link_o, last_link);
        chk("R9 vector hold", vector_o, last_vec);
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule